// File: doc/BRIEF.md
# Translation Table Base Register Guard

This block is the control-register bank that an interrupt translation unit uses to locate its in-memory tables. It has eight 64-bit slots. Slot 0 points at the device table and slot 1 at the collection table. Slots 2 to 7 are spare.

Software reaches the bank through a simple single-cycle request port. Each request carries a write strobe, a slot index, a width flag and write data. The bank answers one clock later with read data, an error pulse or a lock warning pulse.

On every accepted write the bank stores the new value but overwrites the fields it owns itself:
- the per-entry size,
- the table type,
- the two-level bit.

From the stored value it computes how many entries the table can hold and presents that count on dedicated outputs. The count is zero whenever the valid bit is clear. While the unit enable input is high, both table base registers are frozen.

Top module: `tbl_base_guard`

## Requirements
- R1: After reset, slot 0 reads 0x0107_0000_0000_0000, slot 1 reads 0x0401_0000_0000_0000, and both count outputs are zero.
- R2: A legal write to slot 0 or slot 1 while `unit_en` is high leaves the register and both counts unchanged. It also raises `lock_warn` for exactly one cycle, in the cycle after the request.
- R3: After a write, the entry-size field (bits 52:48) holds the entry bytes minus one: 7 in slot 0 (8-byte entries) and 1 in slot 1 (2-byte entries), whatever was written.
- R4: After a write, the type field (bits 58:56) holds 1 in slot 0 and 4 in slot 1, whatever was written.
- R5: After a write, the two-level bit (bit 62) always reads 0.
- R6: When the stored valid bit (bit 63) is set, the count is (size field bits 7:0 plus 1) × 4096 / entry bytes. That is (size+1)×512 for devices and (size+1)×2048 for collections. The count output updates in the cycle after the write request.
- R7: When the stored valid bit is clear, the corresponding count output is zero.
- R8: Slots 2 to 7 ignore writes, read back as zero, and never raise `lock_warn`.
- R9: A request with `req_wide` low is a bad-width access. It changes no state, returns zero data, and pulses `rsp_err` in the cycle after the request.
- R10: A legal read of slot 0 or 1 returns the stored value on `rsp_data` in the cycle after the request. Bits outside the fields of R3 to R5 are stored exactly as written. In every cycle without such a read, `rsp_data` is zero.
- R11: The device count is clamped to 2^`DEV_ID_BITS`. With the default of 16 bits, a size field of 255 gives 65536 instead of 131072.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unit_en | input | 1 | Translation unit enabled; freezes the table base registers |
| req | input | 1 | Request valid for this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = legal 64-bit access, 0 = bad width |
| req_slot | input | SLOT_AW | Slot index 0..7 |
| req_wdata | input | 64 | Write data |
| rsp_data | output | 64 | Read data, one cycle after a read |
| rsp_err | output | 1 | Bad-width error pulse |
| lock_warn | output | 1 | Pulse for a write refused while enabled |
| max_dev_cnt | output | CNT_W | Usable device-table entries |
| max_coll_cnt | output | CNT_W | Usable collection-table entries |

## Verification
The bench targets the following corner cases:
- a write refused while enabled: a design that ignored the lock would change the count and the read value;
- a write whose data sets every read-only bit: a missing override would leak the written entry size, type or two-level bit;
- a valid write with a size field of 255: an unclamped device count would exceed the ID space;
- a write with valid clear: a stale count would remain;
- a spare-slot write: a leak would change the read data or raise a warning;
- narrow accesses: a bad-width write that slipped through would update a count.

// File: rtl/tbg_pkg.sv
package tbg_pkg;
  localparam int REG_W      = 64;
  localparam int SIZE_LO    = 0;
  localparam int SIZE_W     = 8;
  localparam int ESZ_LO     = 48;
  localparam int ESZ_W      = 5;
  localparam int TYPE_LO    = 56;
  localparam int TYPE_W     = 3;
  localparam int INDIR_BIT  = 62;
  localparam int VALID_BIT  = 63;
  localparam int PAGE_BYTES = 4096;
  localparam int NUM_TBL    = 2;

  localparam logic [TYPE_W-1:0] TYPE_DEVICE = 3'd1;
  localparam logic [TYPE_W-1:0] TYPE_COLL   = 3'd4;

  // Fields the bank owns: entry size, type and the two-level bit.
  localparam logic [REG_W-1:0] RO_MASK =
      ({{(REG_W-ESZ_W){1'b0}}, {ESZ_W{1'b1}}} << ESZ_LO) |
      ({{(REG_W-TYPE_W){1'b0}}, {TYPE_W{1'b1}}} << TYPE_LO) |
      (64'd1 << INDIR_BIT);
endpackage

// File: rtl/tbg_entry_calc.sv
module tbg_entry_calc
  import tbg_pkg::*;
#(
  parameter int ENTRY_BYTES = 8,
  parameter int LIMIT_BITS  = 16,
  parameter int CNT_W       = 21
) (
  input  logic [REG_W-1:0] bar,
  output logic [CNT_W-1:0] entries
);
  localparam int SHIFT = $clog2(PAGE_BYTES / ENTRY_BYTES);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(1) << LIMIT_BITS;

  logic [CNT_W-1:0] pages;
  logic [CNT_W-1:0] raw;

  always_comb begin
    pages = CNT_W'(bar[SIZE_LO +: SIZE_W]) + CNT_W'(1);
    raw   = pages << SHIFT;
    if (!bar[VALID_BIT])
      entries = '0;
    else if (raw > LIMIT)
      entries = LIMIT;
    else
      entries = raw;
  end
endmodule

// File: rtl/tbg_slot.sv
module tbg_slot
  import tbg_pkg::*;
#(
  parameter int               ENTRY_BYTES = 8,
  parameter logic [TYPE_W-1:0] TYPE_CODE  = TYPE_DEVICE,
  parameter int               LIMIT_BITS  = 16,
  parameter int               CNT_W       = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] value,
  output logic [CNT_W-1:0] count
);
  localparam logic [ESZ_W-1:0] ESZ_CODE = ESZ_W'(ENTRY_BYTES - 1);
  localparam logic [REG_W-1:0] FIXED =
      ({{(REG_W-ESZ_W){1'b0}}, ESZ_CODE} << ESZ_LO) |
      ({{(REG_W-TYPE_W){1'b0}}, TYPE_CODE} << TYPE_LO);

  logic [REG_W-1:0] clean;
  logic [CNT_W-1:0] next_count;

  assign clean = (wdata & ~RO_MASK) | FIXED;

  tbg_entry_calc #(
    .ENTRY_BYTES(ENTRY_BYTES),
    .LIMIT_BITS (LIMIT_BITS),
    .CNT_W      (CNT_W)
  ) u_calc (
    .bar    (clean),
    .entries(next_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= FIXED;
      count <= '0;
    end else if (wr_en) begin
      value <= clean;
      count <= next_count;
    end
  end
endmodule

// File: rtl/tbl_base_guard.sv
module tbl_base_guard
  import tbg_pkg::*;
#(
  parameter int DEV_ID_BITS = 16,
  parameter int SLOT_AW     = 3,
  parameter int CNT_W       = 21
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               unit_en,
  input  logic               req,
  input  logic               req_we,
  input  logic               req_wide,
  input  logic [SLOT_AW-1:0] req_slot,
  input  logic [REG_W-1:0]   req_wdata,
  output logic [REG_W-1:0]   rsp_data,
  output logic               rsp_err,
  output logic               lock_warn,
  output logic [CNT_W-1:0]   max_dev_cnt,
  output logic [CNT_W-1:0]   max_coll_cnt
);
  logic [REG_W-1:0] tbl_val [NUM_TBL];
  logic [CNT_W-1:0] tbl_cnt [NUM_TBL];
  logic             acc_ok, is_tbl, wr_open, locked, rd_hit;

  assign acc_ok  = req && req_wide;
  assign is_tbl  = req_slot < SLOT_AW'(NUM_TBL);
  assign wr_open = acc_ok && req_we && !unit_en;
  assign locked  = acc_ok && req_we && unit_en && is_tbl;
  assign rd_hit  = acc_ok && !req_we && is_tbl;

  for (genvar g = 0; g < NUM_TBL; g++) begin : g_tbl
    tbg_slot #(
      .ENTRY_BYTES(g == 0 ? 8 : 2),
      .TYPE_CODE  (g == 0 ? TYPE_DEVICE : TYPE_COLL),
      .LIMIT_BITS (g == 0 ? DEV_ID_BITS : CNT_W - 1),
      .CNT_W      (CNT_W)
    ) u_slot (
      .clk  (clk),
      .rst  (rst),
      .wr_en(wr_open && (req_slot == SLOT_AW'(g))),
      .wdata(req_wdata),
      .value(tbl_val[g]),
      .count(tbl_cnt[g])
    );
  end

  assign max_dev_cnt  = tbl_cnt[0];
  assign max_coll_cnt = tbl_cnt[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
      lock_warn <= 1'b0;
    end else begin
      rsp_err   <= req && !req_wide;
      lock_warn <= locked;
      rsp_data  <= rd_hit ? tbl_val[req_slot[0]] : '0;
    end
  end
endmodule

// File: rtl/tbl_base_guard_chk.sv
module tbl_base_guard_chk
  import tbg_pkg::*;
#(
  parameter int DEV_ID_BITS = 16,
  parameter int SLOT_AW     = 3,
  parameter int CNT_W       = 21
) (
  input logic               clk,
  input logic               rst,
  input logic               unit_en,
  input logic               req,
  input logic               req_we,
  input logic               req_wide,
  input logic [SLOT_AW-1:0] req_slot,
  input logic [REG_W-1:0]   rsp_data,
  input logic               rsp_err,
  input logic               lock_warn,
  input logic [CNT_W-1:0]   max_dev_cnt,
  input logic [CNT_W-1:0]   max_coll_cnt
);
  localparam logic [CNT_W-1:0] DEV_LIMIT = CNT_W'(1) << DEV_ID_BITS;

  assert_warn_cause_R2: assert property (@(posedge clk) disable iff (rst)
    lock_warn |-> $past(req && req_we && req_wide && unit_en && (req_slot < SLOT_AW'(2))));

  assert_locked_stable_R2: assert property (@(posedge clk) disable iff (rst)
    (req && req_we && unit_en) |=> ($stable(max_dev_cnt) && $stable(max_coll_cnt)));

  assert_bad_width_err_R9: assert property (@(posedge clk) disable iff (rst)
    (req && !req_wide) |=> (rsp_err && rsp_data == '0 && $stable(max_dev_cnt) && $stable(max_coll_cnt)));

  assert_spare_no_warn_R8: assert property (@(posedge clk) disable iff (rst)
    (req && req_we && (req_slot >= SLOT_AW'(2))) |=> !lock_warn);

  assert_dev_clamp_R11: assert property (@(posedge clk) disable iff (rst)
    max_dev_cnt <= DEV_LIMIT);

  assert_coll_granule_R6: assert property (@(posedge clk) disable iff (rst)
    max_coll_cnt[10:0] == '0);

  assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_err, lock_warn}));
endmodule

bind tbl_base_guard tbl_base_guard_chk #(
  .DEV_ID_BITS(DEV_ID_BITS), .SLOT_AW(SLOT_AW), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .unit_en(unit_en), .req(req), .req_we(req_we),
  .req_wide(req_wide), .req_slot(req_slot), .rsp_data(rsp_data),
  .rsp_err(rsp_err), .lock_warn(lock_warn), .max_dev_cnt(max_dev_cnt),
  .max_coll_cnt(max_coll_cnt)
);

// File: tb/test_tbl_base_guard.sv
module test_tbl_base_guard;
  logic        clk = 0;
  logic        rst = 1;
  logic        unit_en = 0, req = 0, req_we = 0, req_wide = 1;
  logic [2:0]  req_slot = 0;
  logic [63:0] req_wdata = 0;
  logic [63:0] rsp_data;
  logic        rsp_err, lock_warn;
  logic [20:0] max_dev_cnt, max_coll_cnt;

  integer checks = 0, errors = 0, cyc = 0;
  logic   live = 0;

  always #4 clk = ~clk;

  tbl_base_guard i_tbl_base_guard (
    .clk(clk), .rst(rst), .unit_en(unit_en), .req(req), .req_we(req_we),
    .req_wide(req_wide), .req_slot(req_slot), .req_wdata(req_wdata),
    .rsp_data(rsp_data), .rsp_err(rsp_err), .lock_warn(lock_warn),
    .max_dev_cnt(max_dev_cnt), .max_coll_cnt(max_coll_cnt));

  // Behavioural reference model
  logic [63:0] m_reg [2];
  logic [63:0] m_data;
  logic        m_err, m_warn;
  longint      m_cnt [2];

  function automatic logic [63:0] fix(input int s, input logic [63:0] d);
    logic [63:0] v = d;
    v[52:48] = (s == 0) ? 5'd7 : 5'd1;
    v[58:56] = (s == 0) ? 3'd1 : 3'd4;
    v[62]    = 1'b0;
    return v;
  endfunction

  function automatic longint cnt_of(input int s, input logic [63:0] v);
    longint n;
    if (!v[63]) return 0;
    n = (longint'(v[7:0]) + 1) * ((s == 0) ? 512 : 2048);
    if (s == 0 && n > 65536) n = 65536;
    return n;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_reg[0] <= fix(0, 0); m_reg[1] <= fix(1, 0);
      m_cnt[0] <= 0; m_cnt[1] <= 0;
      m_data <= 0; m_err <= 0; m_warn <= 0;
    end else begin
      m_data <= 0; m_err <= 0; m_warn <= 0;
      if (req) begin
        if (!req_wide) m_err <= 1;
        else if (req_we) begin
          if (req_slot < 2) begin
            if (unit_en) m_warn <= 1;
            else begin
              m_reg[req_slot] <= fix(int'(req_slot), req_wdata);
              m_cnt[req_slot] <= cnt_of(int'(req_slot), req_wdata);
            end
          end
        end else if (req_slot < 2) m_data <= m_reg[req_slot];
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) if (live) begin
    chk("R10 rsp_data", rsp_data, m_data);
    chk("R9 rsp_err", longint'(rsp_err), longint'(m_err));
    chk("R2 lock_warn", longint'(lock_warn), longint'(m_warn));
    chk("R6 max_dev_cnt", longint'(max_dev_cnt), m_cnt[0]);
    chk("R6 max_coll_cnt", longint'(max_coll_cnt), m_cnt[1]);
  end

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  task automatic op(input logic we, input logic wide, input int s, input logic [63:0] d);
    req = 1; req_we = we; req_wide = wide; req_slot = 3'(s); req_wdata = d;
    @(posedge clk); @(negedge clk);
    req = 0; req_we = 0; req_wide = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0; live = 1;
    // R1 reset state
    chk("R1 dev cnt", longint'(max_dev_cnt), 0);
    chk("R1 coll cnt", longint'(max_coll_cnt), 0);
    op(0, 1, 0, 0); chk("R1 slot0", rsp_data, 64'h0107_0000_0000_0000);
    op(0, 1, 1, 0); chk("R1 slot1", rsp_data, 64'h0401_0000_0000_0000);
    // R3 R4 R5: all-ones write, valid set, size 3
    op(1, 1, 0, 64'hFFFF_FFFF_FFFF_FF03);
    chk("R6 dev cnt size3", longint'(max_dev_cnt), 2048);
    op(0, 1, 0, 0); chk("R3 R4 R5 slot0 sanitize", rsp_data, 64'hB9E7_FFFF_FFFF_FF03);
    op(1, 1, 1, 64'h8000_0000_0000_0010);
    chk("R6 coll cnt size16", longint'(max_coll_cnt), 34816);
    op(0, 1, 1, 0); chk("R10 R4 slot1", rsp_data, 64'h8401_0000_0000_0010);
    // R7 valid clear
    op(1, 1, 0, 64'h0000_1234_5678_00FF);
    chk("R7 dev cnt zero", longint'(max_dev_cnt), 0);
    op(0, 1, 0, 0); chk("R10 slot0 stored", rsp_data, 64'h0107_1234_5678_00FF);
    // R11 clamp
    op(1, 1, 0, 64'h8000_0000_0000_00FF);
    chk("R11 clamp", longint'(max_dev_cnt), 65536);
    // R2 locked write
    unit_en = 1;
    op(1, 1, 1, 64'h8000_0000_0000_0000);
    chk("R2 warn", longint'(lock_warn), 1);
    chk("R2 coll kept", longint'(max_coll_cnt), 34816);
    @(negedge clk); chk("R2 warn one cycle", longint'(lock_warn), 0);
    op(0, 1, 1, 0); chk("R2 slot1 kept", rsp_data, 64'h8401_0000_0000_0010);
    op(1, 1, 5, 64'hDEAD_BEEF_0000_0001);
    chk("R8 no warn enabled spare", longint'(lock_warn), 0);
    unit_en = 0;
    // R8 spare slots
    op(1, 1, 5, 64'hDEAD_BEEF_1234_5678);
    chk("R8 no warn", longint'(lock_warn), 0);
    op(0, 1, 5, 0); chk("R8 spare reads zero", rsp_data, 0);
    op(0, 1, 7, 0); chk("R8 slot7 zero", rsp_data, 0);
    // R9 bad width
    op(1, 0, 0, 64'h8000_0000_0000_0000);
    chk("R9 err write", longint'(rsp_err), 1);
    chk("R9 dev kept", longint'(max_dev_cnt), 65536);
    op(0, 0, 1, 0);
    chk("R9 err read", longint'(rsp_err), 1);
    chk("R9 data zero", rsp_data, 0);
    op(0, 1, 0, 0); chk("R9 slot0 kept", rsp_data, 64'h8107_0000_0000_00FF);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule